// File: doc/BRIEF.md
# Periodic Tick Interrupt Generator

This block raises a periodic interrupt from the free-running prescaler counter that a real-time counter also uses. It keeps no counter of its own. A 4-bit period code chooses one bit of that shared 15-bit prescaler. Each time the chosen bit drops from 1 to 0, the block sets a sticky flag. Software clears the flag by writing a one to it, which appears here as a one-cycle strobe.

An interrupt-enable input gates the flag onto the interrupt request. For a middle band of intervals the block also emits a one-cycle event pulse. The generator has its own enable, separate from the main counter's. The shared prescaler counts while either the main counter or this generator is active, and holds its value when neither is.

The prescaler value is brought out on a port so that the main counter can share it.

Top module: `pit_tick_gen`

## Requirements
- R1: After reset the prescaler value is 0, and the flag, interrupt request and event pulse are all 0.
- R2: The prescaler adds one on every clock in which `main_active` or `pit_en` is high. It keeps its value when both are low.
- R3: With period code k in 1..14, a set flag appears once every 2^(k+1) clocks (code 1 gives 4, code 14 gives 32768). It is set on the clock edge at which prescaler bit k (bit 0 is the LSB) changes from 1 to 0.
- R4: Period code 0 (off) and code 15 (reserved) never set the flag.
- R5: While `pit_en` is low the flag is never set, even if the prescaler keeps counting because `main_active` is high.
- R6: A high `flag_clr` in a clock with no tick clears the flag at that clock edge.
- R7: When a tick and `flag_clr` fall in the same clock, the flag is set after that edge.
- R8: `pit_irq` is high exactly when the flag is set and `irq_en` is high.
- R9: For period codes 5..12 (64 to 8192 clocks), every tick also produces a `pit_evt` pulse one clock long, in the same cycle in which the flag becomes set.
- R10: Period codes outside 5..12 never produce `pit_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_active | input | 1 | Main counter is enabled, so the shared prescaler must count |
| period_code | input | 4 | Interval select: 0 off, 1..14 gives 2^(code+1) clocks, 15 reserved |
| pit_en | input | 1 | Enable of the periodic generator |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| prescale_cnt | output | 15 | Shared prescaler value |
| pit_flag | output | 1 | Sticky periodic flag |
| pit_irq | output | 1 | Interrupt request |
| pit_evt | output | 1 | One-clock event pulse for band intervals |

## Verification
The interval is measured between two successive flag settings for the shortest code, two middle codes and the longest code. The measurement detects a tap chosen one bit off and a tick taken on the wrong edge of the bit. Codes 0 and 15 are each run for a window in which code 1 would tick several times, which shows that the off and reserved codes are decoded.

The event output is tried at both ends of its band and one code beyond each end, so an off-by-one in the band limits shows up. A clear strobe placed exactly on a tick checks the set-over-clear precedence. Running the prescaler from the main enable alone shows that the generator's enable gates the flag and not the counting.

// File: rtl/pit_pkg.sv
package pit_pkg;

   // Width of the interval select code
   localparam int unsigned PIT_CODE_W = 4;

   typedef logic [PIT_CODE_W-1:0] pit_code_t;

   // Code that disables ticking
   localparam pit_code_t PIT_CODE_OFF = '0;

   // True when a code lies inside an inclusive band
   function automatic logic code_in_band(input pit_code_t code,
                                         input int unsigned lo,
                                         input int unsigned hi);
      return (int'(code) >= int'(lo)) && (int'(code) <= int'(hi));
   endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
   parameter int unsigned WIDTH = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   output logic [WIDTH-1:0] cnt_o
);

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (run_i)
         cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R2
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |=> cnt_q == WIDTH'($past(cnt_q) + 1'b1));

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> $stable(cnt_q));

endmodule

// File: rtl/pit_tap_select.sv
module pit_tap_select
   import pit_pkg::*;
#(
   parameter int unsigned PRESC_W     = 15,
   parameter int unsigned EVT_LO_CODE = 5,
   parameter int unsigned EVT_HI_CODE = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PRESC_W-1:0] cnt_i,
   input  logic               en_i,
   input  pit_code_t          code_i,
   output logic               tick_o,
   output logic               band_o
);

   localparam int unsigned NUM_CODES = 2 ** PIT_CODE_W;
   localparam int unsigned MAX_CODE  = PRESC_W - 1;

   // Per-code wrap detect: the low bits up to the tap are all ones,
   // so the next increment drops the tap bit from 1 to 0.
   logic [NUM_CODES-1:0] wrap_vec;

   for (genvar g = 0; g < NUM_CODES; g++) begin : g_tap
      if (g >= 1 && g <= MAX_CODE) begin : g_live
         assign wrap_vec[g] = &cnt_i[g:0];
      end else begin : g_dead
         assign wrap_vec[g] = 1'b0;
      end
   end

   assign tick_o = en_i & wrap_vec[code_i];
   assign band_o = code_in_band(code_i, EVT_LO_CODE, EVT_HI_CODE);

   // R3
   tap_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !cnt_i[$past(code_i)]);

   // R4
   off_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i == PIT_CODE_OFF || int'(code_i) > int'(MAX_CODE)) |-> !tick_o);

endmodule

// File: rtl/pit_flag_unit.sv
module pit_flag_unit #(
   parameter bit EVT_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic band_i,
   input  logic clr_i,
   input  logic irq_en_i,
   output logic flag_o,
   output logic irq_o,
   output logic evt_o
);

   logic flag_q;

   // A tick takes precedence over a clear strobe in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (tick_i)
         flag_q <= 1'b1;
      else if (clr_i)
         flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
   assign irq_o  = flag_q & irq_en_i;

   if (EVT_EN) begin : g_evt
      logic evt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            evt_q <= 1'b0;
         else
            evt_q <= tick_i & band_i;
      end
      assign evt_o = evt_q;

      // R9
      evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         evt_q |-> flag_q);
   end else begin : g_no_evt
      assign evt_o = 1'b0;
   end

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> flag_q);

   // R6
   clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !tick_i) |=> !flag_q);

endmodule

// File: rtl/pit_tick_gen.sv
module pit_tick_gen
   import pit_pkg::*;
#(
   parameter int unsigned PRESC_W     = 15,
   parameter int unsigned EVT_LO_CODE = 5,
   parameter int unsigned EVT_HI_CODE = 12,
   parameter bit          EVT_EN      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               main_active,
   input  logic [3:0]         period_code,
   input  logic               pit_en,
   input  logic               irq_en,
   input  logic               flag_clr,
   output logic [PRESC_W-1:0] prescale_cnt,
   output logic               pit_flag,
   output logic               pit_irq,
   output logic               pit_evt
);

   localparam int unsigned MAX_CODE = PRESC_W - 1;

   // Elaboration-time parameter checks
   if (PRESC_W < 2 || MAX_CODE >= 2 ** PIT_CODE_W) begin : g_bad_width
      $error("pit_tick_gen: PRESC_W out of range for the code width");
   end
   if (EVT_LO_CODE < 1 || EVT_HI_CODE > MAX_CODE || EVT_LO_CODE > EVT_HI_CODE) begin : g_bad_band
      $error("pit_tick_gen: event band outside the valid codes");
   end

   logic      presc_run;
   logic      tick;
   logic      band;
   pit_code_t code;

   assign code      = pit_code_t'(period_code);
   assign presc_run = main_active | pit_en;

   pit_prescaler #(.WIDTH(PRESC_W)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (presc_run),
      .cnt_o (prescale_cnt)
   );

   pit_tap_select #(
      .PRESC_W     (PRESC_W),
      .EVT_LO_CODE (EVT_LO_CODE),
      .EVT_HI_CODE (EVT_HI_CODE)
   ) u_tap (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_i  (prescale_cnt),
      .en_i   (pit_en),
      .code_i (code),
      .tick_o (tick),
      .band_o (band)
   );

   pit_flag_unit #(.EVT_EN(EVT_EN)) u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .band_i   (band),
      .clr_i    (flag_clr),
      .irq_en_i (irq_en),
      .flag_o   (pit_flag),
      .irq_o    (pit_irq),
      .evt_o    (pit_evt)
   );

   // R5
   gate_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pit_en |=> !$rose(pit_flag));

   // R10
   evt_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pit_evt |-> ($past(period_code) >= 4'(EVT_LO_CODE) && $past(period_code) <= 4'(EVT_HI_CODE)));

   // R8
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pit_flag |-> !pit_irq);

endmodule

// File: tb/sim_pit_tick_gen.sv
`timescale 1ns/1ps
module sim_pit_tick_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        main_active = 1'b0;
   logic [3:0]  period_code = 4'd0;
   logic        pit_en = 1'b0;
   logic        irq_en = 1'b0;
   logic        flag_clr = 1'b0;
   logic [14:0] prescale_cnt;
   logic        pit_flag;
   logic        pit_irq;
   logic        pit_evt;

   int   errors = 0;
   int   checks = 0;
   bit   done = 1'b0;
   logic [14:0] pc_last;

   always #4 clk = ~clk;

   pit_tick_gen u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .main_active  (main_active),
      .period_code  (period_code),
      .pit_en       (pit_en),
      .irq_en       (irq_en),
      .flag_clr     (flag_clr),
      .prescale_cnt (prescale_cnt),
      .pit_flag     (pit_flag),
      .pit_irq      (pit_irq),
      .pit_evt      (pit_evt)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_flag();
      for (int i = 0; i < 8; i++) begin
         flag_clr = 1'b1;
         @(negedge clk);
         flag_clr = 1'b0;
         if (!pit_flag) break;
      end
   endtask

   // Waits until the flag reads set; keeps the prescaler value of the prior sample
   task automatic wait_set(input int limit, output bit ok);
      ok = 1'b0;
      for (int i = 0; i < limit; i++) begin
         pc_last = prescale_cnt;
         @(negedge clk);
         if (pit_flag) begin
            ok = 1'b1;
            break;
         end
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(prescale_cnt == 15'd0, "R1 prescaler", prescale_cnt, 0);
      check(pit_flag == 1'b0, "R1 flag", pit_flag, 0);
      check(pit_irq == 1'b0, "R1 irq", pit_irq, 0);
      check(pit_evt == 1'b0, "R1 evt", pit_evt, 0);
   endtask

   task automatic t_run_gate();
      logic [14:0] c0;
      bit seen;
      period_code = 4'd1;
      main_active = 1'b1;
      pit_en = 1'b0;
      c0 = prescale_cnt;
      @(negedge clk);
      check(prescale_cnt == c0 + 15'd1, "R2 main counts", prescale_cnt, c0 + 1);
      seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (pit_flag) seen = 1'b1;
      end
      check(!seen, "R5 disabled no flag", seen, 0);
      main_active = 1'b0;
      @(negedge clk);
      c0 = prescale_cnt;
      repeat (10) @(negedge clk);
      check(prescale_cnt == c0, "R2 idle holds", prescale_cnt, c0);
      pit_en = 1'b1;
      c0 = prescale_cnt;
      repeat (3) @(negedge clk);
      check(prescale_cnt == c0 + 15'd3, "R2 pit keeps counting", prescale_cnt, c0 + 3);
   endtask

   task automatic t_period(input int code);
      int  per;
      int  n;
      bit  ok;
      per = 1 << (code + 1);
      period_code = 4'(code);
      pit_en = 1'b1;
      @(negedge clk);
      wait_set(per + 8, ok);
      clear_flag();
      wait_set(per + 8, ok);
      check(ok, "R3 tick seen", ok, 1);
      check(pc_last[code] == 1'b1 && prescale_cnt[code] == 1'b0, "R3 tap falls",
            {pc_last[code], prescale_cnt[code]}, 2);
      n = 0;
      flag_clr = 1'b1;
      do begin
         @(negedge clk);
         flag_clr = 1'b0;
         n++;
      end while (!pit_flag && n < per + 8);
      check(n == per, $sformatf("R3 interval code %0d", code), n, per);
   endtask

   task automatic t_off(input int code);
      bit seen;
      period_code = 4'(code);
      pit_en = 1'b1;
      @(negedge clk);
      clear_flag();
      seen = 1'b0;
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         if (pit_flag || pit_evt) seen = 1'b1;
      end
      check(!seen, $sformatf("R4 code %0d silent", code), seen, 0);
   endtask

   task automatic t_clear_irq();
      bit ok;
      period_code = 4'd3;
      pit_en = 1'b1;
      irq_en = 1'b0;
      clear_flag();
      wait_set(40, ok);
      check(pit_flag && !pit_irq, "R8 masked irq", pit_irq, 0);
      irq_en = 1'b1;
      @(negedge clk);
      check(pit_irq == 1'b1, "R8 irq asserted", pit_irq, 1);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      check(pit_flag == 1'b0, "R6 clear", pit_flag, 0);
      check(pit_irq == 1'b0, "R8 irq drops", pit_irq, 0);
      irq_en = 1'b0;
   endtask

   task automatic t_collide();
      bit ok;
      period_code = 4'd1;
      pit_en = 1'b1;
      wait_set(16, ok);
      for (int i = 0; i < 8; i++) begin
         if (prescale_cnt[1:0] == 2'b11) break;
         @(negedge clk);
      end
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      check(pit_flag == 1'b1, "R7 set beats clear", pit_flag, 1);
   endtask

   task automatic t_event(input int code, input bit exp_evt);
      bit ok;
      int per;
      per = 1 << (code + 1);
      period_code = 4'(code);
      pit_en = 1'b1;
      @(negedge clk);
      clear_flag();
      wait_set(per + 8, ok);
      if (exp_evt) begin
         check(ok && pit_evt, $sformatf("R9 evt code %0d", code), pit_evt, 1);
         @(negedge clk);
         check(pit_evt == 1'b0, "R9 evt one clock", pit_evt, 0);
      end else begin
         check(ok && !pit_evt, $sformatf("R10 no evt code %0d", code), pit_evt, 0);
      end
   endtask

   initial begin
      t_reset();
      t_run_gate();
      t_period(1);
      t_period(2);
      t_period(6);
      t_period(14);
      t_off(0);
      t_off(15);
      t_clear_irq();
      t_collide();
      t_event(5, 1'b1);
      t_event(12, 1'b1);
      t_event(4, 1'b0);
      t_event(13, 1'b0);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule